// File: doc/BRIEF.md
# Single-Wire Return-to-One Device Responder

This block is the device end of a single-wire, return-to-one serial link. The host starts a transaction by holding the shared line low long enough to count as a break. It then releases the line and sends bit frames. Each frame begins with a falling edge, and the length of the low part carries the bit value. The responder measures each low pulse, which tells a break apart from a data bit and a 0 apart from a 1. It collects a command byte, least-significant bit first. Command bit 7 chooses the direction and the remaining bits give a register address.

For a write command, the next received byte goes to an external register file as a single-cycle write strobe. For a read command, the responder waits a fixed turnaround time and then reads the addressed register. It sends that byte back on the line through an open-drain pull-down enable. The line input is expected to be synchronised to `clk` already, and the open-drain output only ever pulls low. The register-file port has no back-pressure: a write strobe is accepted in the cycle it is raised, and read data is combinational from `rf_addr`.

All timing is counted in `clk` cycles through parameters.

Top module: `rt1_responder`

## Requirements
- R1: After reset the line is released (`drive_low` = 0), no write strobe is raised, and the responder waits for a break. Bit frames that arrive before the first break are ignored.
- R2: A low level held for BRK_CYC or more cycles after a falling edge is a break. From any state it returns the receiver to waiting for a fresh command, and it abandons any response that is being sent.
- R3: After a break, bit frames are accepted only once the line has stayed high for REC_CYC consecutive cycles. A frame that arrives earlier is discarded.
- R4: A frame's value is taken SAMPLE_CYC cycles after its falling edge. A high line at that point means 1 and a low line means 0, provided the low part stays shorter than a break.
- R5: Bytes are received and sent least-significant bit first. In a command byte, bit 7 = 1 means write, bit 7 = 0 means read, and bits ADDR_W-1:0 give the register address.
- R6: After a write command, the next 8 received bits are presented on `rf_wdata` with `rf_addr` during a single-cycle `rf_we` pulse. The responder then accepts another command with no break in between.
- R7: After a read command, the responder keeps the line released for TURN_CYC cycles and then sends the addressed register as 8 frames of TX_BIT_CYC cycles each. It pulls low for TX_LOW_CYC cycles for a 1 and for TX_DATA_CYC cycles for a 0.
- R8: A break that arrives while a data byte is partly received discards that byte: no write strobe is raised.
- R9: After the 8th response frame, the responder accepts another command with no break in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 1 | Synchronised level of the shared line |
| drive_low | output | 1 | Open-drain enable; 1 pulls the line low |
| rf_addr | output | ADDR_W | Register address of the current command |
| rf_we | output | 1 | Single-cycle write strobe |
| rf_wdata | output | 8 | Write data, valid with `rf_we` |
| rf_rdata | input | 8 | Read data of the register at `rf_addr` |

## Verification
The bench aims at the cases where pulse-width decoding can go wrong.

- **Frames sent before any break.** A responder that did not gate these would raise a write strobe that nobody asked for.
- **Break cutting a data byte.** A responder that kept the partial byte would still complete a write.
- **Break followed by too short a high time and a stray bit.** A responder with a weak recovery gate would take the stray bit into the next command. The later read would then come back from the wrong register.
- **Traffic with no break in between.** Writes and reads run back-to-back, with patterns of all zeros, all ones and alternating bits at the lowest and highest addresses. These expose bit-order mistakes, a wrong direction bit, and a wrong return to command reception after a write or a response.

The bench also measures every pulse width and the turnaround gap of each response.

// File: rtl/rt1_pkg.sv
package rt1_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REC,
    ST_CMD,
    ST_WDATA,
    ST_TURN,
    ST_TX
  } rsp_state_t;
endpackage

// File: rtl/rt1_pulse_rx.sv
module rt1_pulse_rx #(
  parameter int SAMPLE_CYC = 12,
  parameter int BRK_CYC    = 40,
  parameter int REC_CYC    = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic bit_vld,
  output logic bit_val,
  output logic brk,
  output logic rec_ok
);
  localparam int CW = $clog2(BRK_CYC + 1);
  localparam int HW = $clog2(REC_CYC + 1);
  localparam logic [CW-1:0] SMP_PT = CW'(SAMPLE_CYC);
  localparam logic [CW-1:0] BRK_PT = CW'(BRK_CYC - 1);
  localparam logic [HW-1:0] HI_MAX = HW'(REC_CYC);

  typedef enum logic [1:0] {RX_IDLE, RX_EARLY, RX_LOW, RX_HOLD} rx_t;

  rx_t           st;
  logic          line_q;
  logic [CW-1:0] cnt;
  logic [HW-1:0] hcnt;

  assign rec_ok = (hcnt == HI_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= RX_IDLE;
      line_q  <= 1'b1;
      cnt     <= '0;
      hcnt    <= '0;
      bit_vld <= 1'b0;
      bit_val <= 1'b0;
      brk     <= 1'b0;
    end else begin
      bit_vld <= 1'b0;
      brk     <= 1'b0;
      line_q  <= line_in;
      if (!line_in)          hcnt <= '0;
      else if (hcnt != HI_MAX) hcnt <= hcnt + 1'b1;
      case (st)
        RX_IDLE: begin
          if (line_q && !line_in) begin
            st  <= RX_EARLY;
            cnt <= CW'(1);
          end
        end
        RX_EARLY: begin
          cnt <= cnt + 1'b1;
          if (cnt == SMP_PT) begin
            if (line_in) begin
              bit_vld <= 1'b1;
              bit_val <= 1'b1;
              st      <= RX_IDLE;
            end else begin
              st <= RX_LOW;
            end
          end
        end
        RX_LOW: begin
          if (line_in) begin
            bit_vld <= 1'b1;
            bit_val <= 1'b0;
            st      <= RX_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
            if (cnt == BRK_PT) begin
              brk <= 1'b1;
              st  <= RX_HOLD;
            end
          end
        end
        default: begin
          if (line_in) st <= RX_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/rt1_frame_tx.sv
module rt1_frame_tx #(
  parameter int TX_LOW_CYC  = 4,
  parameter int TX_DATA_CYC = 16,
  parameter int TX_BIT_CYC  = 24
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      abort,
  input  logic [rt1_pkg::BYTE_W-1:0] data,
  output logic                      drive_low,
  output logic                      done
);
  localparam int FW = $clog2(TX_BIT_CYC + 1);
  localparam int BW = $clog2(rt1_pkg::BYTE_W);
  localparam logic [FW-1:0] LOW_END  = FW'(TX_LOW_CYC);
  localparam logic [FW-1:0] DATA_END = FW'(TX_DATA_CYC);
  localparam logic [FW-1:0] FR_LAST  = FW'(TX_BIT_CYC - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(rt1_pkg::BYTE_W - 1);

  logic                       busy;
  logic [rt1_pkg::BYTE_W-1:0] sh;
  logic [BW-1:0]              bitn;
  logic [FW-1:0]              fc;

  assign done      = busy && (fc == FR_LAST) && (bitn == BIT_LAST);
  assign drive_low = busy && ((fc < LOW_END) || ((fc < DATA_END) && !sh[0]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sh   <= '0;
      bitn <= '0;
      fc   <= '0;
    end else if (abort) begin
      busy <= 1'b0;
    end else if (start) begin
      busy <= 1'b1;
      sh   <= data;
      bitn <= '0;
      fc   <= '0;
    end else if (busy) begin
      if (fc == FR_LAST) begin
        fc <= '0;
        sh <= sh >> 1;
        if (bitn == BIT_LAST) busy <= 1'b0;
        else                  bitn <= bitn + 1'b1;
      end else begin
        fc <= fc + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rt1_responder.sv
module rt1_responder #(
  parameter int ADDR_W      = 7,
  parameter int SAMPLE_CYC  = 12,
  parameter int BRK_CYC     = 40,
  parameter int REC_CYC     = 20,
  parameter int TURN_CYC    = 30,
  parameter int TX_LOW_CYC  = 4,
  parameter int TX_DATA_CYC = 16,
  parameter int TX_BIT_CYC  = 24
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       line_in,
  output logic                       drive_low,
  output logic [ADDR_W-1:0]          rf_addr,
  output logic                       rf_we,
  output logic [rt1_pkg::BYTE_W-1:0] rf_wdata,
  input  logic [rt1_pkg::BYTE_W-1:0] rf_rdata
);
  import rt1_pkg::*;

  localparam int TW = $clog2(TURN_CYC + 1);
  localparam logic [TW-1:0] TURN_LAST = TW'(TURN_CYC - 1);
  localparam int BW = $clog2(BYTE_W);
  localparam logic [BW-1:0] BIT_LAST = BW'(BYTE_W - 1);

  rsp_state_t        state;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] nxt_byte;
  logic [BW-1:0]     bcnt;
  logic [TW-1:0]     tcnt;
  logic              bit_vld, bit_val, brk, rec_ok;
  logic              tx_start, tx_done;

  rt1_pulse_rx #(
    .SAMPLE_CYC(SAMPLE_CYC), .BRK_CYC(BRK_CYC), .REC_CYC(REC_CYC)
  ) u_rx (
    .clk(clk), .rst_n(rst_n), .line_in(line_in),
    .bit_vld(bit_vld), .bit_val(bit_val), .brk(brk), .rec_ok(rec_ok)
  );

  rt1_frame_tx #(
    .TX_LOW_CYC(TX_LOW_CYC), .TX_DATA_CYC(TX_DATA_CYC), .TX_BIT_CYC(TX_BIT_CYC)
  ) u_tx (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .abort(brk),
    .data(rf_rdata), .drive_low(drive_low), .done(tx_done)
  );

  assign nxt_byte = {bit_val, shreg[BYTE_W-1:1]};
  assign rf_wdata = nxt_byte;
  assign rf_we    = (state == ST_WDATA) && bit_vld && (bcnt == BIT_LAST);
  assign tx_start = (state == ST_TURN) && (tcnt == TURN_LAST) && !brk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      shreg   <= '0;
      bcnt    <= '0;
      tcnt    <= '0;
      rf_addr <= '0;
    end else if (brk) begin
      state <= ST_REC;
      bcnt  <= '0;
    end else begin
      case (state)
        ST_REC: begin
          bcnt <= '0;
          if (rec_ok) state <= ST_CMD;
        end
        ST_CMD: begin
          if (bit_vld) begin
            shreg <= nxt_byte;
            bcnt  <= bcnt + 1'b1;
            if (bcnt == BIT_LAST) begin
              rf_addr <= nxt_byte[ADDR_W-1:0];
              tcnt    <= '0;
              state   <= nxt_byte[BYTE_W-1] ? ST_WDATA : ST_TURN;
            end
          end
        end
        ST_WDATA: begin
          if (bit_vld) begin
            shreg <= nxt_byte;
            bcnt  <= bcnt + 1'b1;
            if (bcnt == BIT_LAST) state <= ST_CMD;
          end
        end
        ST_TURN: begin
          tcnt <= tcnt + 1'b1;
          if (tcnt == TURN_LAST) state <= ST_TX;
        end
        ST_TX: begin
          if (tx_done) begin
            state <= ST_CMD;
            bcnt  <= '0;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rt1_responder_chk.sv
module rt1_responder_chk (
  input logic               clk,
  input logic               rst_n,
  input logic               brk,
  input logic               bit_vld,
  input logic               rf_we,
  input logic               drive_low,
  input rt1_pkg::rsp_state_t state
);
  import rt1_pkg::*;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (!drive_low && !rf_we));

  assert_brk_rearm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    brk |=> (state == ST_REC));

  assert_rec_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_REC && bit_vld && !brk) |=> (state == ST_REC || state == ST_CMD));

  assert_wr_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> (state == ST_CMD));

  assert_drive_only_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    drive_low |-> (state == ST_TX));

  assert_turn_before_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TX && $past(state) != ST_TX) |-> ($past(state) == ST_TURN));
endmodule

bind rt1_responder rt1_responder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .brk(brk), .bit_vld(bit_vld),
  .rf_we(rf_we), .drive_low(drive_low), .state(state)
);

// File: tb/rt1_responder_test.sv
`timescale 1ns/1ps
module rt1_responder_test;
  localparam int SAMPLE_CYC = 12;
  localparam int TURN_CYC   = 30;
  localparam int TX_LOW     = 4;
  localparam int TX_DATA    = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_low = 1'b0;
  logic       dev_low;
  logic       line;
  logic [6:0] rf_addr;
  logic       rf_we;
  logic [7:0] rf_wdata;
  logic [7:0] rf_rdata;

  logic [7:0]  mem     [128];
  logic [7:0]  exp_mem [128];
  logic [7:0]  exp_rd [$];
  logic [14:0] exp_wr [$];

  int checks = 0, fails = 0;
  int cyc = 0, last_host_fall = 0, writes_seen = 0;
  int lo_len = 0, rbits = 0;
  bit prev_dev = 1'b0, wok = 1'b1;
  logic [7:0] rbyte = '0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  assign line     = !(host_low || dev_low);
  assign rf_rdata = mem[rf_addr];

  rt1_responder uut (
    .clk(clk), .rst_n(rst_n), .line_in(line), .drive_low(dev_low),
    .rf_addr(rf_addr), .rf_we(rf_we), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input bit b);
    int lo;
    lo = b ? 4 : 18;
    @(negedge clk);
    host_low = 1'b1;
    last_host_fall = cyc;
    repeat (lo) @(negedge clk);
    host_low = 1'b0;
    repeat (24 - lo - 1) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic send_break(input int hi_cyc);
    @(negedge clk);
    host_low = 1'b1;
    idle(50);
    host_low = 1'b0;
    idle(hi_cyc);
  endtask

  task automatic do_write(input logic [6:0] a, input logic [7:0] d);
    exp_wr.push_back({a, d});
    exp_mem[a] = d;
    send_byte({1'b1, a});
    send_byte(d);
    idle(4);
  endtask

  task automatic do_read(input logic [6:0] a);
    exp_rd.push_back(exp_mem[a]);
    send_byte({1'b0, a});
    while (exp_rd.size() != 0) @(negedge clk);
    idle(10);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (dev_low) begin
        if (!prev_dev) begin
          lo_len = 1;
          if (rbits == 0)
            chk(cyc - last_host_fall >= SAMPLE_CYC + TURN_CYC, "R7",
                "turnaround gap", cyc - last_host_fall, SAMPLE_CYC + TURN_CYC);
        end else lo_len++;
      end else if (prev_dev) begin
        if (!(lo_len == TX_LOW || lo_len == TX_DATA)) wok = 1'b0;
        rbyte = {(lo_len == TX_LOW), rbyte[7:1]};
        rbits++;
        if (rbits == 8) begin
          if (exp_rd.size() == 0) chk(1'b0, "R7", "unexpected response", rbyte, 0);
          else begin
            logic [7:0] e;
            e = exp_rd.pop_front();
            chk(rbyte == e, "R4 R5 R7", "read byte", rbyte, e);
            chk(wok, "R7", "pulse widths", 0, 1);
          end
          rbits = 0;
          wok = 1'b1;
        end
      end
      prev_dev = dev_low;
      if (rf_we) begin
        writes_seen++;
        mem[rf_addr] = rf_wdata;
        if (exp_wr.size() == 0) chk(1'b0, "R6", "unexpected write", {rf_addr, rf_wdata}, 0);
        else begin
          logic [14:0] e;
          e = exp_wr.pop_front();
          chk({rf_addr, rf_wdata} == e, "R5 R6", "write addr/data", {rf_addr, rf_wdata}, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int w0;
    for (int i = 0; i < 128; i++) begin
      mem[i]     = 8'(i) ^ 8'h3C;
      exp_mem[i] = 8'(i) ^ 8'h3C;
    end
    idle(5);
    rst_n = 1'b1;
    idle(3);
    chk(dev_low == 1'b0 && rf_we == 1'b0, "R1", "reset outputs", {dev_low, rf_we}, 0);

    // R1: frames before any break are ignored
    send_byte(8'h85);
    send_byte(8'h11);
    idle(10);
    chk(writes_seen == 0, "R1", "writes before first break", writes_seen, 0);

    send_break(25);
    do_write(7'd5,   8'hA5);
    do_write(7'd0,   8'h00);
    do_write(7'd127, 8'hFF);
    do_write(7'd64,  8'h5A);
    do_read(7'd5);
    do_read(7'd0);
    do_read(7'd127);
    do_read(7'd64);
    do_read(7'd9);

    // R8 / R2: break in the middle of a data byte
    w0 = writes_seen;
    send_byte({1'b1, 7'd9});
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    send_break(25);
    chk(writes_seen == w0, "R8", "aborted write", writes_seen, w0);
    do_read(7'd9);

    // R3: stray 0-bit during too-short recovery is discarded
    send_break(5);
    send_bit(1'b0);
    idle(25);
    do_read(7'd64);

    // R9 / R6: back-to-back traffic without breaks
    do_write(7'd3, 8'h3C);
    do_read(7'd3);
    do_read(7'd127);

    idle(20);
    chk(exp_rd.size() == 0 && exp_wr.size() == 0, "R6 R7", "pending items",
        exp_rd.size() + exp_wr.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule